// File: doc/BRIEF.md
# Toggle-Mask Interrupt Controller

This block collects sixteen primary interrupt request lines into sticky pending bits and funnels them through an enable mask into one interrupt output for a processor. Each rising edge on a request line latches its pending bit. Software clears pending bits by writing ones to the pending register. Software changes the enable mask by writing the bits it wants flipped: a write XORs into the mask and does not load it.

A small secondary flag register sits in front of the controller. Two secondary request inputs latch flags at the sparse positions 8 and 10. While any flag is set, the controller treats primary line 1 as driven high. The flags are cleared by writing ones to them. The output is registered, so it follows the pending and mask state one clock later.

All accesses use a simple single-cycle register bus. Read data appears on the clock after the read request.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: After reset the pending register, the mask, the secondary flags, irq_o and bus_rdata_o are all zero.
- R2: A rising edge (low in one cycle, high in the next) on line_i[n] sets pending bit n. A line that stays high does not set the bit again after it is cleared.
- R3: A read at offset 0xF000 returns the pending bits in bits 15:0, with zeros above. The read data appears on the clock after the request, and the read does not change the pending bits.
- R4: A write to offset 0xF000 clears each pending bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0xF010 replaces the mask with (mask XOR write data[15:0]). A read at 0xF010 returns the mask.
- R6: irq_o is high exactly one clock after a cycle in which (pending AND mask) is nonzero, and low one clock after a cycle in which it is zero.
- R7: A rising edge on sec_i[0] sets flag bit 8 and a rising edge on sec_i[1] sets flag bit 10 of the flag register at offset 0xF230. No other flag bit is ever set.
- R8: A write to offset 0xF230 clears each flag bit whose write-data bit is 1.
- R9: Primary line 1 is taken as line_i[1] OR (any flag set). A rising edge of that combined level sets pending bit 1.
- R10: When a set and a write-one clear reach the same pending bit or flag bit in the same cycle, the bit ends up set.
- R11: Reads of any other offset return zero. Writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_vld_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one clock after a read request |
| line_i | input | 16 | Primary request lines |
| sec_i | input | 2 | Secondary request lines |
| irq_o | output | 1 | Interrupt output to the processor |

## Verification
Two kinds of event can hit the same register bit in one cycle: a request edge that sets the bit, and a software write-one that clears it. The bench creates this collision in both the pending register and the flag register. It raises the request line on the same falling clock edge where it drives the clearing write, so both land on the next rising edge. It then reads the register back and expects the bit to be set. It also checks that a request line held high does not set the bit again after it is cleared.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 16'hF000;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 16'hF010;
  localparam logic [ADDR_W-1:0] OFS_SFLAG = 16'hF230;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_MASK,
    SEL_SFLAG
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr);
    case (addr)
      OFS_PEND:  return SEL_PEND;
      OFS_MASK:  return SEL_MASK;
      OFS_SFLAG: return SEL_SFLAG;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[i] <= 1'b0;
      else         lvl_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_en_i ? clr_i : '0;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_eff) | set_i;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R10

  AST_CLR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_en_i) |=> (q_o == ($past(q_o) & ~$past(clr_i)))); // R4

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && !clr_en_i) |=> $stable(q_o)); // R3
endmodule

// File: rtl/irq_toggle_mask.sv
module irq_toggle_mask #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] tog_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (wr_i) mask_o <= mask_o ^ tog_i;
  end

  AST_MASK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_o)); // R5

  AST_MASK_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((mask_o ^ $past(mask_o)) == $past(tog_i))); // R5
endmodule

// File: rtl/irq_toggle_ctrl.sv
module irq_toggle_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_LINES   = 16,
  parameter int unsigned SEC_N     = 2,
  parameter int unsigned SEC_BASE  = 8,
  parameter int unsigned SEC_STEP  = 2,
  parameter int unsigned CASC_LINE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_vld_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_LINES-1:0] line_i,
  input  logic [SEC_N-1:0]  sec_i,
  output logic              irq_o
);
  localparam int unsigned FLAG_W = SEC_BASE + SEC_STEP * (SEC_N - 1) + 1;

  reg_sel_e           sel;
  logic               wr, rd;
  logic [SEC_N-1:0]   sec_rise;
  logic [FLAG_W-1:0]  flag_set, flag_ok, flag_q;
  logic               any_flag;
  logic [N_LINES-1:0] eff_lines, prim_rise, pend_q, mask_q;
  logic [DATA_W-1:0]  rdata_d;

  assign sel = decode_addr(bus_addr_i);
  assign wr  = bus_vld_i & bus_we_i;
  assign rd  = bus_vld_i & ~bus_we_i;

  // secondary flags at sparse positions
  irq_edge_det #(.W(SEC_N)) i_sec_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sec_i),
    .rise_o(sec_rise)
  );

  for (genvar b = 0; b < FLAG_W; b++) begin : g_flag_map
    if ((b >= SEC_BASE) && (((b - SEC_BASE) % SEC_STEP) == 0)) begin : g_used
      assign flag_set[b] = sec_rise[(b - SEC_BASE) / SEC_STEP];
      assign flag_ok[b]  = 1'b1;
    end else begin : g_gap
      assign flag_set[b] = 1'b0;
      assign flag_ok[b]  = 1'b0;
    end
  end

  irq_w1c_reg #(.W(FLAG_W)) i_flag_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_en_i(wr && (sel == SEL_SFLAG)),
    .clr_i   (bus_wdata_i[FLAG_W-1:0]),
    .q_o     (flag_q)
  );

  assign any_flag = |flag_q;

  // cascade the flag group into one primary line
  for (genvar n = 0; n < N_LINES; n++) begin : g_eff
    if (n == CASC_LINE) begin : g_casc
      assign eff_lines[n] = line_i[n] | any_flag;
    end else begin : g_plain
      assign eff_lines[n] = line_i[n];
    end
  end

  irq_edge_det #(.W(N_LINES)) i_prim_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (eff_lines),
    .rise_o(prim_rise)
  );

  irq_w1c_reg #(.W(N_LINES)) i_pend_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (prim_rise),
    .clr_en_i(wr && (sel == SEL_PEND)),
    .clr_i   (bus_wdata_i[N_LINES-1:0]),
    .q_o     (pend_q)
  );

  irq_toggle_mask #(.W(N_LINES)) i_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr && (sel == SEL_MASK)),
    .tog_i (bus_wdata_i[N_LINES-1:0]),
    .mask_o(mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(pend_q & mask_q);
  end

  always_comb begin
    rdata_d = '0;
    case (sel)
      SEL_PEND:  rdata_d = DATA_W'(pend_q);
      SEL_MASK:  rdata_d = DATA_W'(mask_q);
      SEL_SFLAG: rdata_d = DATA_W'(flag_q);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bus_rdata_o <= '0;
    else if (rd)  bus_rdata_o <= rdata_d;
  end

  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_q & mask_q)) |=> irq_o); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & mask_q) == '0) |=> !irq_o); // R6

  AST_FLAG_SPARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ~flag_ok) == '0)); // R7

  AST_CASC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(any_flag) && !$past(line_i[CASC_LINE]) && !line_i[CASC_LINE]) |=> pend_q[CASC_LINE]); // R9
endmodule

// File: tb/test_irq_toggle_ctrl.sv
module test_irq_toggle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] line = '0;
  logic [1:0]  sec = '0;
  logic        irq;

  int n_vec = 0, n_err = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_due = 1'b0;

  always #5 clk = ~clk;

  irq_toggle_ctrl i_irq_toggle_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_vld_i(vld), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .line_i(line), .sec_i(sec), .irq_o(irq)
  );

  always @(posedge clk) rd_due <= vld & ~we;

  // monitor: pop expected read data when a response is due
  always @(negedge clk) begin
    if (rd_due && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (rdata !== e) begin
        n_err++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); vld = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); vld = 0; we = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    @(negedge clk); vld = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); vld = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_vec++;
    if (irq !== e) begin
      n_err++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    idle(2);
    n_vec++;
    if (irq !== 1'b0 || rdata !== 32'h0) begin
      n_err++;
      $display("FAIL R1: irq=%b rdata=%h expected=0 0", irq, rdata);
    end
    rst_n = 1'b1;
    rd(16'hF000, 32'h0, "R1 pending");
    rd(16'hF010, 32'h0, "R1 mask");
    rd(16'hF230, 32'h0, "R1 flags");
    chk_irq(1'b0, "R1 irq");

    // edges on lines 3 and 12
    @(negedge clk); line[3] = 1; line[12] = 1;
    rd(16'hF000, 32'h1008, "R2 set");
    rd(16'hF000, 32'h1008, "R3 read keeps");
    chk_irq(1'b0, "R6 masked");

    wr(16'hF010, 32'h0008);
    rd(16'hF010, 32'h0008, "R5 toggle on");
    chk_irq(1'b1, "R6 enabled");
    wr(16'hF010, 32'h0009);
    rd(16'hF010, 32'h0001, "R5 xor");
    chk_irq(1'b0, "R6 disabled");

    wr(16'hF000, 32'h0008);
    rd(16'hF000, 32'h1000, "R4 w1c");
    rd(16'hF000, 32'h1000, "R2 held level no reset");

    @(negedge clk); line[3] = 0;
    wr(16'hF010, 32'h1001);
    rd(16'hF010, 32'h1000, "R5 mask");
    chk_irq(1'b1, "R6 line12");
    wr(16'hF000, 32'h1000);
    idle(1);
    chk_irq(1'b0, "R6 cleared");

    // set and clear collide on bit 5
    @(negedge clk); vld = 1; we = 1; addr = 16'hF000; wdata = 32'h20; line[5] = 1;
    @(negedge clk); vld = 0; we = 0;
    rd(16'hF000, 32'h0020, "R10 pending set wins");
    wr(16'hF000, 32'h20);
    rd(16'hF000, 32'h0, "R4 cleared");

    // secondary flags
    @(negedge clk); sec[0] = 1;
    rd(16'hF230, 32'h0100, "R7 flag8");
    rd(16'hF000, 32'h0002, "R9 cascade");
    @(negedge clk); sec[1] = 1;
    rd(16'hF230, 32'h0500, "R7 flag10");
    wr(16'hF230, 32'h0100);
    rd(16'hF230, 32'h0400, "R8 w1c");
    wr(16'hF000, 32'h0002);
    rd(16'hF000, 32'h0, "R9 no new edge");
    wr(16'hF230, 32'h0400);
    rd(16'hF230, 32'h0, "R8 all clear");
    @(negedge clk); sec[1] = 0;
    idle(1);
    @(negedge clk); vld = 1; we = 1; addr = 16'hF230; wdata = 32'h400; sec[1] = 1;
    @(negedge clk); vld = 0; we = 0;
    rd(16'hF230, 32'h0400, "R10 flag set wins");
    rd(16'hF000, 32'h0002, "R9 re-cascade");

    wr(16'hF010, 32'h1002);
    chk_irq(1'b1, "R6 cascade line");
    wr(16'hF000, 32'h0002);
    idle(1);
    chk_irq(1'b0, "R6 cascade cleared");

    wr(16'hF020, 32'hFFFF);
    rd(16'hF020, 32'h0, "R11 unmapped read");
    rd(16'hF010, 32'h0002, "R11 mask untouched");
    rd(16'hF000, 32'h0, "R11 pending untouched");

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule